// File: doc/BRIEF.md
# Configurable External Chip-Enable Decoder

This block sits on the external memory bus of an 8-bit microcontroller. It watches each bus cycle's 24-bit address and drives two kinds of shared port pins. Up to eight active-low chip enables, in two banks of four, select the external memory device that owns the address. Up to six upper address lines, starting at A16, reach the external devices. Each chip enable covers a window whose size is programmable from 32 kB to 4 MB. The number of enables in each bank is programmable as well. Any pin that is not needed as an address line or as an enable falls back to the value held in a software port latch, so it stays available as general-purpose I/O.

Three small fields hold the configuration. These are the window size and one enable count per bank. They are loaded through a plain write port. A synchronous reset reloads them with defaults that depend on whether the boot ROM is enabled at the time of reset. All pins are plain level signals and there is no handshake. The decode is combinational from the address, the strobe and the stored fields. A field write changes the outputs from the clock edge that stores it.

Top module: `ext_ce_decoder`

## Requirements
- R1: After a synchronous reset with `boot_rom_en` low, the size field is 111, the bank-0 count is 111 and the bank-1 count is 000. All six address pins carry A16–A21, CE0–CE3 are enabled, and the `pin_ce[7:4]` pins carry the I/O latch.
- R2: After a synchronous reset with `boot_rom_en` high, the size field is 101 (2 MB) and both bank counts are 111. Address pin 5 carries its I/O latch and all eight chip enables are enabled.
- R3: The size field sets the window per chip enable. Code 000 gives 2^15 bytes. Codes 001 to 101 give 2^(16+code) bytes. Codes 110 and 111 both give 2^22 bytes.
- R4: Address pin j (j = 0..5) drives address bit 16+j when j is below the line count, and otherwise drives `gpio_addr[j]`. The line count is 0 for size 000, equal to the code for 001–101, and 6 for 110/111.
- R5: A bank count field of 0xx enables no chip enable in that bank. A field of 1nn enables the bank's pins 0 through nn.
- R6: The chip-enable index is the address shifted right by the window width. Bank b pin k is chip enable 4b+k. An enabled chip enable drives 0 exactly when the strobe is high and the index equals its number. An index with no enabled chip enable, including any index above 7, asserts none.
- R7: A chip-enable pin that is not enabled drives its bit of `gpio_ce`.
- R8: While `bus_strobe` is low, every enabled chip-enable pin drives 1.
- R9: A write with `cfg_wr` high at `cfg_addr` 0, 1 or 2 stores `cfg_wdata[2:0]` into the size field, the bank-0 count or the bank-1 count. The outputs change from that clock edge. The upper data bits, writes to address 3 and cycles with `cfg_wr` low change nothing.
- R10: `boot_rom_en` is sampled only while `rst` is high. Each reset reloads the defaults of R1 or R2, whatever was written before.
- R11: At most one enabled chip-enable pin is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration fields |
| rst | input | 1 | Synchronous reset, active high |
| boot_rom_en | input | 1 | Selects the boot-ROM defaults while reset is high |
| cfg_wr | input | 1 | Field write strobe |
| cfg_addr | input | 2 | Field select: 0 size, 1 bank-0 count, 2 bank-1 count |
| cfg_wdata | input | 8 | Write data; bits 2:0 are stored |
| bus_addr | input | 24 | Address of the current bus cycle |
| bus_strobe | input | 1 | High while a bus cycle is in progress |
| gpio_addr | input | 6 | Port latch values for the address pins |
| gpio_ce | input | 8 | Port latch values for the chip-enable pins |
| pin_addr | output | 6 | Shared pins carrying A16–A21 or latch values |
| pin_ce | output | 8 | Shared pins carrying active-low chip enables or latch values |

## Verification
The case that is hardest to reach is an address that computes to a real index while that index lands on a disabled enable or beyond the eighth one. This happens with small windows and short counts, where the upper address bits select a chip enable that the count field has not granted. The stimulus table reaches it by pairing each window size with count fields that stop just below the selected index. It also uses addresses whose high bits give indices such as 8 and 22. The boot-ROM defaults matter too, and so does the cycle at which a write takes effect. These are reached by resetting with the boot input high, dropping that input, and then sampling the pins both before and after the edge that stores a write.

// File: rtl/ced_pkg.sv
package ced_pkg;
  localparam int FIELD_W = 3;
  typedef logic [FIELD_W-1:0] ced_field_t;

  localparam ced_field_t FIELD_ALL = '1;
  localparam ced_field_t FIELD_OFF = '0;
  // window code used after a reset with the boot ROM enabled
  localparam ced_field_t BOOT_SIZE = 3'd5;
endpackage

// File: rtl/ced_cfg_regs.sv
module ced_cfg_regs
  import ced_pkg::*;
#(
  parameter int N_BANKS = 2,
  parameter int CFG_AW  = 2,
  parameter int CFG_DW  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        boot_rom_en,
  input  logic                        cfg_wr,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [CFG_DW-1:0]           cfg_wdata,
  output ced_field_t                  size_q,
  output ced_field_t [N_BANKS-1:0]    cnt_q
);

  ced_field_t wr_field;
  logic       unused_wdata_hi;

  assign wr_field        = cfg_wdata[FIELD_W-1:0];
  assign unused_wdata_hi = ^cfg_wdata[CFG_DW-1:FIELD_W];

  // field 0: window size
  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= boot_rom_en ? BOOT_SIZE : FIELD_ALL;
    end else if (cfg_wr && (cfg_addr == CFG_AW'(0))) begin
      size_q <= wr_field;
    end
  end

  // fields 1..N_BANKS: enable count per bank
  for (genvar b = 0; b < N_BANKS; b++) begin : g_cnt
    localparam ced_field_t RST_PLAIN = (b == 0) ? FIELD_ALL : FIELD_OFF;
    ced_field_t cnt_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_r <= boot_rom_en ? FIELD_ALL : RST_PLAIN;
      end else if (cfg_wr && (cfg_addr == CFG_AW'(b + 1))) begin
        cnt_r <= wr_field;
      end
    end

    assign cnt_q[b] = cnt_r;
  end

endmodule

// File: rtl/ced_window.sv
module ced_window
  import ced_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int BASE_SHIFT  = 15,
  parameter int N_ADDR_PINS = 6,
  parameter int IDX_W       = ADDR_W - BASE_SHIFT
) (
  input  ced_field_t              size_q,
  input  logic [ADDR_W-1:0]       bus_addr,
  output logic [IDX_W-1:0]        idx,
  output logic [N_ADDR_PINS-1:0]  line_mask
);

  localparam int SH_W = $clog2(ADDR_W);
  localparam int LN_W = $clog2(N_ADDR_PINS + 1);

  logic [SH_W-1:0] sh;
  logic [LN_W-1:0] lines;

  // window width and number of upper address lines for each size code
  always_comb begin
    if (size_q == FIELD_OFF) begin
      sh    = SH_W'(BASE_SHIFT);
      lines = '0;
    end else if (int'(size_q) >= N_ADDR_PINS) begin
      sh    = SH_W'(BASE_SHIFT + 1 + N_ADDR_PINS);
      lines = LN_W'(N_ADDR_PINS);
    end else begin
      sh    = SH_W'(BASE_SHIFT + 1 + int'(size_q));
      lines = LN_W'(size_q);
    end
  end

  assign idx = IDX_W'(bus_addr >> sh);

  for (genvar j = 0; j < N_ADDR_PINS; j++) begin : g_mask
    assign line_mask[j] = (LN_W'(j) < lines);
  end

endmodule

// File: rtl/ced_addr_mux.sv
module ced_addr_mux #(
  parameter int N_ADDR_PINS = 6
) (
  input  logic [N_ADDR_PINS-1:0] line_mask,
  input  logic [N_ADDR_PINS-1:0] hi_addr,
  input  logic [N_ADDR_PINS-1:0] gpio_addr,
  output logic [N_ADDR_PINS-1:0] pin_addr
);

  for (genvar j = 0; j < N_ADDR_PINS; j++) begin : g_pin
    assign pin_addr[j] = line_mask[j] ? hi_addr[j] : gpio_addr[j];
  end

endmodule

// File: rtl/ced_bank.sv
module ced_bank
  import ced_pkg::*;
#(
  parameter int PINS     = 4,
  parameter int BANK_IDX = 0,
  parameter int IDX_W    = 9
) (
  input  ced_field_t        cnt,
  input  logic [IDX_W-1:0]  idx,
  input  logic              strobe,
  input  logic [PINS-1:0]   gpio,
  output logic [PINS-1:0]   pin,
  output logic [PINS-1:0]   en
);

  localparam int SEL_W = FIELD_W - 1;

  // top bit of the count turns the bank on; low bits name its last pin
  for (genvar k = 0; k < PINS; k++) begin : g_ce
    logic hit;
    assign en[k]  = cnt[FIELD_W-1] && (SEL_W'(k) <= cnt[SEL_W-1:0]);
    assign hit    = strobe && (idx == IDX_W'(BANK_IDX * PINS + k));
    assign pin[k] = en[k] ? ~hit : gpio[k];
  end

endmodule

// File: rtl/ext_ce_decoder.sv
module ext_ce_decoder
  import ced_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int BASE_SHIFT  = 15,
  parameter int N_ADDR_PINS = 6,
  parameter int N_BANKS     = 2,
  parameter int CE_PER_BANK = 4,
  parameter int CFG_AW      = 2,
  parameter int CFG_DW      = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            boot_rom_en,
  input  logic                            cfg_wr,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [CFG_DW-1:0]               cfg_wdata,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_strobe,
  input  logic [N_ADDR_PINS-1:0]          gpio_addr,
  input  logic [N_BANKS*CE_PER_BANK-1:0]  gpio_ce,
  output logic [N_ADDR_PINS-1:0]          pin_addr,
  output logic [N_BANKS*CE_PER_BANK-1:0]  pin_ce
);

  localparam int IDX_W        = ADDR_W - BASE_SHIFT;
  localparam int N_CE         = N_BANKS * CE_PER_BANK;
  localparam int ADDR_PIN_LSB = BASE_SHIFT + 1;

  ced_field_t                 size_q;
  ced_field_t [N_BANKS-1:0]   cnt_q;
  logic [IDX_W-1:0]           idx;
  logic [N_ADDR_PINS-1:0]     line_mask;
  logic [N_CE-1:0]            ce_en_mask;

  ced_cfg_regs #(
    .N_BANKS (N_BANKS),
    .CFG_AW  (CFG_AW),
    .CFG_DW  (CFG_DW)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .boot_rom_en (boot_rom_en),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .size_q      (size_q),
    .cnt_q       (cnt_q)
  );

  ced_window #(
    .ADDR_W      (ADDR_W),
    .BASE_SHIFT  (BASE_SHIFT),
    .N_ADDR_PINS (N_ADDR_PINS),
    .IDX_W       (IDX_W)
  ) u_win (
    .size_q    (size_q),
    .bus_addr  (bus_addr),
    .idx       (idx),
    .line_mask (line_mask)
  );

  ced_addr_mux #(
    .N_ADDR_PINS (N_ADDR_PINS)
  ) u_amux (
    .line_mask (line_mask),
    .hi_addr   (bus_addr[ADDR_PIN_LSB +: N_ADDR_PINS]),
    .gpio_addr (gpio_addr),
    .pin_addr  (pin_addr)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    ced_bank #(
      .PINS     (CE_PER_BANK),
      .BANK_IDX (b),
      .IDX_W    (IDX_W)
    ) u_bank (
      .cnt    (cnt_q[b]),
      .idx    (idx),
      .strobe (bus_strobe),
      .gpio   (gpio_ce[b*CE_PER_BANK +: CE_PER_BANK]),
      .pin    (pin_ce[b*CE_PER_BANK +: CE_PER_BANK]),
      .en     (ce_en_mask[b*CE_PER_BANK +: CE_PER_BANK])
    );
  end

endmodule

// File: rtl/ced_chk.sv
module ced_chk
  import ced_pkg::*;
#(
  parameter int N_CE        = 8,
  parameter int N_ADDR_PINS = 6,
  parameter int CFG_AW      = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_wr,
  input logic [CFG_AW-1:0]       cfg_addr,
  input ced_field_t              wr_field,
  input ced_field_t              size_q,
  input logic                    bus_strobe,
  input logic [1:0]              top_sel,
  input logic [N_ADDR_PINS-1:0]  gpio_addr,
  input logic [N_CE-1:0]         gpio_ce,
  input logic [N_CE-1:0]         ce_en,
  input logic [N_ADDR_PINS-1:0]  pin_addr,
  input logic [N_CE-1:0]         pin_ce
);

  logic size_wr;
  assign size_wr = cfg_wr && (cfg_addr == CFG_AW'(0));

  // R11
  single_ce_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ce_en & ~pin_ce));

  // R8
  idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe |-> ((ce_en & ~pin_ce) == '0));

  // R7
  free_ce_pin_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_ce ^ gpio_ce) & ~ce_en) == '0);

  // R4
  small_window_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (size_q == FIELD_OFF) |-> (pin_addr == gpio_addr));

  // R3
  full_window_select_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && (size_q == FIELD_ALL) && ce_en[top_sel]) |-> !pin_ce[top_sel]);

  // R9
  size_load_chk: assert property (@(posedge clk) disable iff (rst)
    size_wr |=> (size_q == $past(wr_field)));

  // R9
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !size_wr |=> $stable(size_q));

endmodule

bind ext_ce_decoder ced_chk #(
  .N_CE        (N_BANKS * CE_PER_BANK),
  .N_ADDR_PINS (N_ADDR_PINS),
  .CFG_AW      (CFG_AW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .wr_field   (cfg_wdata[ced_pkg::FIELD_W-1:0]),
  .size_q     (size_q),
  .bus_strobe (bus_strobe),
  .top_sel    (bus_addr[ADDR_W-1 -: 2]),
  .gpio_addr  (gpio_addr),
  .gpio_ce    (gpio_ce),
  .ce_en      (ce_en_mask),
  .pin_addr   (pin_addr),
  .pin_ce     (pin_ce)
);

// File: tb/ext_ce_decoder_bench.sv
`timescale 1ns/1ps
module ext_ce_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_rom_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] bus_addr = '0;
  logic        bus_strobe = 1'b0;
  logic [5:0]  gpio_addr = 6'h2A;
  logic [7:0]  gpio_ce = 8'hA5;
  logic [5:0]  pin_addr;
  logic [7:0]  pin_ce;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ext_ce_decoder u_ext_ce_decoder (
    .clk         (clk),
    .rst         (rst),
    .boot_rom_en (boot_rom_en),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .bus_addr    (bus_addr),
    .bus_strobe  (bus_strobe),
    .gpio_addr   (gpio_addr),
    .gpio_ce     (gpio_ce),
    .pin_addr    (pin_addr),
    .pin_ce      (pin_ce)
  );

  // {size, bank0 count, bank1 count, strobe, address, expected pin_addr, expected pin_ce}
  // latches: gpio_addr = 6'h2A, gpio_ce = 8'hA5
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    {3'd7, 3'd7, 3'd0, 1'b1, 24'h5A1234, 6'h1A, 8'hAD},  // index 1 -> CE1
    {3'd7, 3'd7, 3'd0, 1'b0, 24'h5A1234, 6'h1A, 8'hAF},  // strobe low
    {3'd0, 3'd7, 3'd7, 1'b1, 24'h008000, 6'h2A, 8'hFD},  // 32 kB, CE1
    {3'd0, 3'd4, 3'd0, 1'b1, 24'h008000, 6'h2A, 8'hA5},  // CE1 not enabled
    {3'd0, 3'd7, 3'd5, 1'b1, 24'h028000, 6'h2A, 8'h9F},  // index 5 -> CE5
    {3'd0, 3'd7, 3'd7, 1'b1, 24'h040000, 6'h2A, 8'hFF},  // index 8 -> none
    {3'd1, 3'd6, 3'd0, 1'b1, 24'h050000, 6'h2B, 8'hA3},  // 128 kB, CE2, A16
    {3'd3, 3'd7, 3'd7, 1'b1, 24'hB70000, 6'h2F, 8'hFF},  // index 22 -> none
    {3'd5, 3'd7, 3'd7, 1'b1, 24'hE50000, 6'h25, 8'h7F},  // 2 MB, CE7
    {3'd6, 3'd5, 3'd0, 1'b1, 24'hC00001, 6'h00, 8'hA7},  // CE3 beyond count
    {3'd4, 3'd7, 3'd6, 1'b1, 24'h6FFFFF, 6'h2F, 8'hBF},  // 1 MB, CE6
    {3'd2, 3'd3, 3'd0, 1'b1, 24'h000000, 6'h28, 8'hA5}   // count 0xx -> none
  };

  task automatic check(input string tag, input logic [5:0] exp_a, input logic [7:0] exp_c);
    n_chk++;
    if (pin_addr !== exp_a || pin_ce !== exp_c) begin
      n_fail++;
      $display("FAIL %s: pin_addr=%h pin_ce=%h, expected pin_addr=%h pin_ce=%h",
               tag, pin_addr, pin_ce, exp_a, exp_c);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst         = 1'b1;
    boot_rom_en = boot;
    @(negedge clk);
    rst         = 1'b0;
    boot_rom_en = 1'b0;
  endtask

  task automatic drive_bus(input logic [23:0] a, input logic s);
    @(negedge clk);
    bus_addr   = a;
    bus_strobe = s;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset(1'b0);

    // R1: plain defaults, index 3 with 4 MB windows
    drive_bus(24'hC10000, 1'b1);
    check("R1 default map", 6'h01, 8'hA7);
    // R8: strobe low releases the enable
    drive_bus(24'hC10000, 1'b0);
    check("R8 strobe low", 6'h01, 8'hAF);
    // R6: lowest and highest address
    drive_bus(24'h000000, 1'b1);
    check("R6 address zero", 6'h00, 8'hAE);
    drive_bus(24'hFFFFFF, 1'b1);
    check("R6 address top", 6'h3F, 8'hA7);

    // R3 R4 R5 R6 R7 R8 table
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      cfg_write(2'd0, {5'd0, v[47:45]});
      cfg_write(2'd1, {5'd0, v[44:42]});
      cfg_write(2'd2, {5'd0, v[41:39]});
      drive_bus(v[37:14], v[38]);
      check($sformatf("R3 R4 R5 R6 R7 vector %0d", i), v[13:8], v[7:0]);
    end

    // R2 R10: boot-ROM defaults, boot input dropped after reset
    do_reset(1'b1);
    drive_bus(24'hE00000, 1'b1);
    check("R2 boot default map", 6'h20, 8'h7F);

    // R9: data on the port without cfg_wr changes nothing
    @(negedge clk);
    cfg_addr  = 2'd0;
    cfg_wdata = 8'h00;
    @(negedge clk);
    #1;
    check("R9 no strobe", 6'h20, 8'h7F);

    // R9: address 3 is not a field
    cfg_write(2'd3, 8'h00);
    #1;
    check("R9 unused address", 6'h20, 8'h7F);

    // R9: write lands at the next edge
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_addr  = 2'd0;
    cfg_wdata = 8'hF8;
    #1;
    check("R9 before edge", 6'h20, 8'h7F);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check("R9 after edge", 6'h2A, 8'hFF);

    // R9 R3: upper data bits dropped, code 001
    cfg_write(2'd0, 8'hF9);
    drive_bus(24'hE10000, 1'b1);
    check("R9 upper bits ignored", 6'h2B, 8'hFF);

    // R10: reset reloads plain defaults over written fields
    do_reset(1'b0);
    drive_bus(24'hC10000, 1'b1);
    check("R10 reload defaults", 6'h01, 8'hA7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule